// File: doc/BRIEF.md
# SIMD Lane Activity Stack Controller

This block decides which of four SIMD lanes carry out the shared instruction stream. Each lane reports one condition bit. Block-structured control flow runs by masking lanes, not by branching. A stack of saved enable masks tracks the nesting, so if/else/endif blocks and data-dependent loops can sit inside one another.

The sequencer drives one strobe per control instruction: if, else, endif, loop-begin, loop-test and loop-end. A loop body repeats while the repeat flag is high. A lane leaves the loop when it fails the loop test, and the flag drops once no lane is left. A push onto a full stack raises a sticky overflow flag. A pop from an empty stack raises a sticky underflow flag. In both cases the current mask is left as it was.

Top module: `lane_mask_stack`

## Requirements
- R1: After reset, all four lanes are enabled (`en_mask` = 4'b1111), the stack is empty, and `repeat_flag`, `overflow` and `underflow` are 0.
- R2: An if strobe saves the current mask on the stack. From the next cycle the mask is the old mask ANDed with `cond`.
- R3: An else strobe leaves the stack as it is. The new mask is the saved top entry ANDed with the inverse of the current mask. This enables the lanes that were active at the matching if and failed its condition.
- R4: An endif strobe pops the stack and restores the saved mask as the current mask.
- R5: A loop-begin strobe saves the current mask on the stack and leaves the mask unchanged.
- R6: A loop-test strobe clears the lanes whose `cond` bit is 0. In the next cycle `repeat_flag` is 1 if any lane is still enabled and 0 otherwise. `repeat_flag` keeps its value until the next loop-test or a successful loop-end.
- R7: A loop-end strobe pops the stack, restores the saved mask and clears `repeat_flag`.
- R8: The stack holds 8 entries. A push (if or loop-begin) when 8 entries are held sets `overflow`. The mask and the stack are left unchanged. The flag stays at 1 until reset.
- R9: An endif, loop-end or else strobe with an empty stack sets `underflow` and leaves the mask unchanged. The flag stays at 1 until reset.
- R10: When several strobes are high in one cycle, only the highest-priority one acts. The order from highest to lowest is if, else, endif, loop-begin, loop-test, loop-end.
- R11: Nested blocks restore masks in last-in first-out order through every level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cond | input | 4 | Per-lane condition bits, bit i for lane i |
| op_if | input | 1 | If strobe |
| op_else | input | 1 | Else strobe |
| op_endif | input | 1 | Endif strobe |
| op_lbeg | input | 1 | Loop-begin strobe |
| op_ltest | input | 1 | Loop-test strobe |
| op_lend | input | 1 | Loop-end strobe |
| en_mask | output | 4 | Current lane enable mask |
| repeat_flag | output | 1 | Loop body should repeat |
| overflow | output | 1 | Sticky push-when-full error |
| underflow | output | 1 | Sticky pop-when-empty error |

## Verification
Every result sits behind exactly one register. The mask, the repeat flag and both error flags therefore take their new value at the first rising edge after the strobe is sampled. The bench drives each strobe on a falling edge and holds it across one rising edge. It then reads all outputs 1 ns after that edge, before any further strobe can act. Stack contents are never read directly. They are brought out by later endif or loop-end strobes, which restore the saved masks to `en_mask`.

// File: rtl/lane_mask_stack.sv
module lane_mask_stack #(
  parameter int LANES = 4,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LANES-1:0] cond,
  input  logic             op_if,
  input  logic             op_else,
  input  logic             op_endif,
  input  logic             op_lbeg,
  input  logic             op_ltest,
  input  logic             op_lend,
  output logic [LANES-1:0] en_mask,
  output logic             repeat_flag,
  output logic             overflow,
  output logic             underflow
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [LANES-1:0] mask_q;
  logic [LANES-1:0] stk [DEPTH];
  logic [CW-1:0]    cnt;
  logic             rep_q, ovf_q, unf_q;

  logic [5:0] sel;
  assign sel[0] = op_if;
  assign sel[1] = op_else  & ~op_if;
  assign sel[2] = op_endif & ~op_if & ~op_else;
  assign sel[3] = op_lbeg  & ~op_if & ~op_else & ~op_endif;
  assign sel[4] = op_ltest & ~op_if & ~op_else & ~op_endif & ~op_lbeg;
  assign sel[5] = op_lend  & ~op_if & ~op_else & ~op_endif & ~op_lbeg & ~op_ltest;

  wire push  = sel[0] | sel[3];
  wire pop   = sel[2] | sel[5];
  wire full  = (cnt == CW'(DEPTH));
  wire empty = (cnt == '0);
  wire [LANES-1:0] top = empty ? '1 : stk[IW'(cnt - 1'b1)];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '1;
      cnt    <= '0;
      rep_q  <= 1'b0;
      ovf_q  <= 1'b0;
      unf_q  <= 1'b0;
    end else begin
      if (push) begin
        if (full) ovf_q <= 1'b1;
        else begin
          stk[IW'(cnt)] <= mask_q;
          cnt <= cnt + 1'b1;
          if (sel[0]) mask_q <= mask_q & cond;
        end
      end
      if (sel[1]) begin
        if (empty) unf_q <= 1'b1;
        else mask_q <= top & ~mask_q;
      end
      if (pop) begin
        if (empty) unf_q <= 1'b1;
        else begin
          cnt    <= cnt - 1'b1;
          mask_q <= top;
          if (sel[5]) rep_q <= 1'b0;
        end
      end
      if (sel[4]) begin
        mask_q <= mask_q & cond;
        rep_q  <= |(mask_q & cond);
      end
    end
  end

  assign en_mask     = mask_q;
  assign repeat_flag = rep_q;
  assign overflow    = ovf_q;
  assign underflow   = unf_q;

  a_r10_one_action: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(sel));
  a_r2_if_narrows: assert property (@(posedge clk) disable iff (!rst_n)
    (op_if && !full) |=> en_mask == ($past(en_mask) & $past(cond)));
  a_r6_repeat_any: assert property (@(posedge clk) disable iff (!rst_n)
    sel[4] |=> repeat_flag == (|en_mask));
  a_r8_overflow_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full) |=> (overflow && $stable(en_mask)));
  a_r9_underflow_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ((pop || sel[1]) && empty) |=> (underflow && $stable(en_mask)));
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n) overflow |=> overflow);
  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n) underflow |=> underflow);
  a_r8_depth_bound: assert property (@(posedge clk) disable iff (!rst_n) cnt <= CW'(DEPTH));
endmodule

// File: tb/sim_lane_mask_stack.sv
module sim_lane_mask_stack;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] cond = '0;
  logic op_if = 0, op_else = 0, op_endif = 0, op_lbeg = 0, op_ltest = 0, op_lend = 0;
  logic [3:0] en_mask;
  logic repeat_flag, overflow, underflow;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  lane_mask_stack u0 (.clk, .rst_n, .cond, .op_if, .op_else, .op_endif, .op_lbeg,
    .op_ltest, .op_lend, .en_mask, .repeat_flag, .overflow, .underflow);

  // op codes: 1 if, 2 else, 3 endif, 4 loop-begin, 5 loop-test, 6 loop-end
  // entry: {op[2:0], cond[3:0], expected mask[3:0], expected repeat}
  localparam logic [11:0] VEC [14] = '{
    {3'd1, 4'b0011, 4'b0011, 1'b0},  // R2
    {3'd1, 4'b0101, 4'b0001, 1'b0},  // R2 nested
    {3'd2, 4'b0000, 4'b0010, 1'b0},  // R3
    {3'd3, 4'b0000, 4'b0011, 1'b0},  // R4
    {3'd2, 4'b0000, 4'b1100, 1'b0},  // R3 outer
    {3'd4, 4'b0000, 4'b1100, 1'b0},  // R5
    {3'd5, 4'b1111, 4'b1100, 1'b1},  // R6
    {3'd5, 4'b0100, 4'b0100, 1'b1},  // R6
    {3'd5, 4'b0000, 4'b0000, 1'b0},  // R6 all out
    {3'd6, 4'b0000, 4'b1100, 1'b0},  // R7
    {3'd3, 4'b0000, 4'b1111, 1'b0},  // R11
    {3'd4, 4'b0000, 4'b1111, 1'b0},  // R5
    {3'd5, 4'b1010, 4'b1010, 1'b1},  // R6
    {3'd6, 4'b0000, 4'b1111, 1'b0}   // R7
  };

  task automatic step(input logic [5:0] ops, input logic [3:0] c);
    @(negedge clk);
    {op_lend, op_ltest, op_lbeg, op_endif, op_else, op_if} = ops;
    cond = c;
    @(posedge clk);
    #1;
    {op_lend, op_ltest, op_lbeg, op_endif, op_else, op_if} = '0;
  endtask

  task automatic check(input string req, input logic [6:0] act, input logic [6:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: {mask,rep,ovf,unf} actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  initial begin
    do_reset();
    check("R1", {en_mask, repeat_flag, overflow, underflow}, 7'b1111_000);

    for (int i = 0; i < 14; i++) begin
      step(6'(1) << (VEC[i][11:9] - 3'd1), VEC[i][8:5]);
      check("R2-R7/R11 vector", {en_mask, repeat_flag, overflow, underflow},
            {VEC[i][4:1], VEC[i][0], 2'b00});
    end

    // R8 overflow
    step(6'b000001, 4'b1110);
    for (int i = 0; i < 7; i++) step(6'b000001, 4'b1111);
    check("R8 full no flag", {en_mask, repeat_flag, overflow, underflow}, 7'b1110_000);
    step(6'b000001, 4'b0000);
    check("R8 overflow", {en_mask, repeat_flag, overflow, underflow}, 7'b1110_010);
    for (int i = 0; i < 7; i++) step(6'b000100, 4'b0000);
    check("R8 stack intact", {en_mask, repeat_flag, overflow, underflow}, 7'b1110_010);
    step(6'b000100, 4'b0000);
    check("R11 bottom", {en_mask, repeat_flag, overflow, underflow}, 7'b1111_010);
    // R9 underflow
    step(6'b000100, 4'b0000);
    check("R9 endif empty", {en_mask, repeat_flag, overflow, underflow}, 7'b1111_011);

    do_reset();
    check("R1 flags cleared", {en_mask, repeat_flag, overflow, underflow}, 7'b1111_000);
    step(6'b000010, 4'b0000);
    check("R9 else empty", {en_mask, repeat_flag, overflow, underflow}, 7'b1111_001);
    do_reset();
    step(6'b100000, 4'b0000);
    check("R9 lend empty", {en_mask, repeat_flag, overflow, underflow}, 7'b1111_001);

    // R10 priority
    do_reset();
    step(6'b111111, 4'b0110);
    check("R10 if wins", {en_mask, repeat_flag, overflow, underflow}, 7'b0110_000);
    step(6'b110100, 4'b0000);
    check("R10 endif over lbeg", {en_mask, repeat_flag, overflow, underflow}, 7'b1111_000);
    step(6'b110000, 4'b0011);
    check("R10 test over lend", {en_mask, repeat_flag, overflow, underflow}, 7'b0011_100);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule